// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the CPU-facing register window of a simple serial port. A 32-bit bus addresses it by word index. Received bytes come in on a valid/data byte stream and go into a receive FIFO. Software reads them back through one of two status/data words. One of those words only peeks at the oldest byte. The other returns that byte and also removes it. A write to the transmit data word sends its low byte out on a transmit byte stream.

The block keeps a raw interrupt register, a mask, a masked view of the two, and an acknowledge word. From these it drives one level-sensitive interrupt line. Receive-data-present is a live raw bit that tracks the FIFO. Transmit writes set two sticky raw bits, which software clears through the acknowledge word. The first acknowledge after a transmit is not allowed to clear bit 0.

Baud generation, bit framing and DMA are handled elsewhere. The control words for those functions are only stored here.

Top module: `uart_reg_front`

## Requirements
- R1: After a synchronous reset, the receive control word (index 2) reads 0x00010000, every other stored word reads 0, `irq`, `tx_valid` and `rx_ready` are low, and the receive FIFO is empty.
- R2: A read of the peek word (index 9) returns the oldest FIFO byte in bits 7:0. Bit 16 is set when the FIFO is not empty. Bits 22 and 24 are always 1, and all other bits are 0. The read never changes the FIFO.
- R3: A read of the pop word (index 8) returns the same layout as the peek word. When the FIFO is not empty it also removes the oldest byte. On an empty FIFO it removes nothing and bit 16 reads 0.
- R4: The FIFO holds DEPTH (16) bytes in arrival order. While it is full, `rx_ready` is low and an offered byte is dropped without disturbing the stored bytes.
- R5: `rx_ready` is high only while bit 3 of the receive control word is 1 and the FIFO is not full. A byte offered while the receiver is disabled is dropped.
- R6: Raw interrupt bit 3 (index 13) is 1 exactly when the FIFO is not empty. An acknowledge cannot clear it.
- R7: A write to the transmit data word (index 7) pulses `tx_valid` for one cycle on the following edge, with `tx_data` equal to bits 7:0 of the written value. The write also sets raw interrupt bits 0 and 1 and sets an internal transmit-pending flag.
- R8: A write to the acknowledge word (index 12) clears every raw interrupt bit that is 1 in the written value. If transmit-pending is set, bit 0 is first removed from the value and transmit-pending is cleared. The acknowledge word reads back the value after this adjustment.
- R9: The masked word (index 14) reads raw AND mask, where the mask is index 11. `irq` is a register that is high one cycle after that AND becomes nonzero and low one cycle after it becomes zero.
- R10: Indexes 0, 1, 3, 4, 5, 6 and 10, and the transmit data and mask words, read back the last 32-bit value written. Writes to indexes 8, 9, 13 and 14 are ignored.
- R11: A byte push and a pop read in the same cycle both take effect. The pop returns the older byte, and the pushed byte stays queued.
- R12: Read data appears on `bus_rdata` with `bus_rvalid` high on the edge after the request. Index 15, outside the 15-word window, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 4 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Receiver enabled and FIFO not full |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The two functions that can fall in the same cycle are the FIFO push from the byte stream and the pop caused by a read of the pop word. The bench first queues one byte. On a single clock edge it then offers a second byte and issues a pop read. The result is judged by two things: the returned byte must be the older one, and afterwards a peek must show the newer byte still queued. A further pop must empty the FIFO, which shows that the fill count neither lost nor gained an entry.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int DATA_W     = 32;
  localparam int BYTE_W     = 8;
  localparam int WIDX_W     = 4;
  localparam int NWORDS     = 15;

  typedef logic [WIDX_W-1:0] widx_t;

  // word indexes; the two status words and the interrupt words are decoded
  localparam widx_t W_TXCTL     = 4'd0;
  localparam widx_t W_TXDMA     = 4'd1;
  localparam widx_t W_RXCTL     = 4'd2;
  localparam widx_t W_DOUT      = 4'd7;
  localparam widx_t W_STAT_POP  = 4'd8;
  localparam widx_t W_STAT_PEEK = 4'd9;
  localparam widx_t W_MASK      = 4'd11;
  localparam widx_t W_ACK       = 4'd12;
  localparam widx_t W_RAW       = 4'd13;
  localparam widx_t W_MASKED    = 4'd14;

  localparam int RX_EN_BIT   = 3;
  localparam int AVAIL_BIT   = 16;
  localparam int TX_IDLE_BIT = 22;
  localparam int TX_RDY_BIT  = 24;
  localparam int RX_IRQ_BIT  = 3;

  localparam logic [DATA_W-1:0] RXCTL_RESET = 32'h0001_0000;
  localparam logic [DATA_W-1:0] TX_IRQ_SET  = 32'h0000_0003;

  // true for words that are plain storage (read back what was written)
  function automatic logic is_plain(input int w);
    return !(w == int'(W_STAT_POP) || w == int'(W_STAT_PEEK) ||
             w == int'(W_RAW) || w == int'(W_MASKED));
  endfunction
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_pop;

  assign empty  = (level == '0);
  assign full   = (level == LW'(DEPTH));
  assign do_pop = pop && !empty;
  assign dout   = mem[rd_ptr];

  // storage has no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push)   wr_ptr <= wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      case ({push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_fire,
  input  logic              ack_fire,
  input  logic [DATA_W-1:0] ack_val,
  input  logic              rx_nonempty,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] masked,
  output logic [DATA_W-1:0] ack_eff,
  output logic              irq
);
  localparam logic [DATA_W-1:0] LIVE_BIT = DATA_W'(1) << RX_IRQ_BIT;

  logic [DATA_W-1:0] sticky_q;
  logic              tx_pend_q;

  // first acknowledge after a transmit spares bit 0
  assign ack_eff = tx_pend_q ? (ack_val & ~DATA_W'(1)) : ack_val;
  assign raw     = (sticky_q & ~LIVE_BIT) | (rx_nonempty ? LIVE_BIT : '0);
  assign masked  = raw & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q  <= '0;
      tx_pend_q <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= |masked;
      if (tx_fire) begin
        sticky_q  <= sticky_q | TX_IRQ_SET;
        tx_pend_q <= 1'b1;
      end else if (ack_fire) begin
        sticky_q  <= sticky_q & ~ack_eff & ~LIVE_BIT;
        tx_pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_reg_bank.sv
module uart_reg_bank
  import uart_reg_pkg::*;
#(
  parameter int NW = NWORDS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  widx_t                    wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [DATA_W-1:0]        ack_data,
  output logic [NW-1:0][DATA_W-1:0] words
);
  for (genvar g = 0; g < NW; g++) begin : g_word
    if (!is_plain(g)) begin : g_none
      assign words[g] = '0;
    end else begin : g_store
      localparam logic [DATA_W-1:0] RV = (g == int'(W_RXCTL)) ? RXCTL_RESET : '0;
      localparam bit IS_ACK = (g == int'(W_ACK));
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= RV;
        else if (wr_en && wr_idx == widx_t'(g)) q <= IS_ACK ? ack_data : wr_data;
      end
      assign words[g] = q;
    end
  end
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
  import uart_reg_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [WIDX_W-1:0] bus_word,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              irq
);
  logic                          in_win, wr_en, rd_en, pop_rd;
  logic [NWORDS-1:0][DATA_W-1:0] words;
  logic [DATA_W-1:0]             ack_eff, irq_raw, irq_masked, mask_word;
  logic [DATA_W-1:0]             status, rd_mux;
  logic [BYTE_W-1:0]             head;
  logic [LW-1:0]                 fifo_level;
  logic                          f_empty, f_full, rx_en, push;

  assign in_win = (int'(bus_word) < NWORDS);
  assign wr_en  = bus_req && bus_we && in_win;
  assign rd_en  = bus_req && !bus_we;
  assign pop_rd = rd_en && (bus_word == W_STAT_POP);

  assign rx_en     = words[W_RXCTL][RX_EN_BIT];
  assign mask_word = words[W_MASK];
  assign rx_ready  = rx_en && !f_full;
  assign push      = rx_valid && rx_ready;

  uart_reg_bank #(.NW(NWORDS)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(bus_word),
    .wr_data(bus_wdata), .ack_data(ack_eff), .words(words)
  );

  uart_rx_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(rx_data), .pop(pop_rd),
    .dout(head), .level(fifo_level), .empty(f_empty), .full(f_full)
  );

  uart_irq_ctrl u_irq (
    .clk(clk), .rst(rst),
    .tx_fire(wr_en && bus_word == W_DOUT),
    .ack_fire(wr_en && bus_word == W_ACK),
    .ack_val(bus_wdata), .rx_nonempty(!f_empty), .mask(mask_word),
    .raw(irq_raw), .masked(irq_masked), .ack_eff(ack_eff), .irq(irq)
  );

  always_comb begin
    status              = '0;
    status[BYTE_W-1:0]  = head;
    status[AVAIL_BIT]   = !f_empty;
    status[TX_IDLE_BIT] = 1'b1;
    status[TX_RDY_BIT]  = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    if (in_win) begin
      case (bus_word)
        W_STAT_POP, W_STAT_PEEK: rd_mux = status;
        W_RAW:                   rd_mux = irq_raw;
        W_MASKED:                rd_mux = irq_masked;
        default:                 rd_mux = words[bus_word];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      tx_valid   <= 1'b0;
      tx_data    <= '0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_mux;
      tx_valid <= wr_en && bus_word == W_DOUT;
      if (wr_en && bus_word == W_DOUT) tx_data <= bus_wdata[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/uart_reg_front_chk.sv
module uart_reg_front_chk
  import uart_reg_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [WIDX_W-1:0] bus_word,
  input logic [BYTE_W-1:0] wbyte,
  input logic              bus_rvalid,
  input logic              tx_valid,
  input logic [BYTE_W-1:0] tx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              irq,
  input logic [LW-1:0]     level,
  input logic [DATA_W-1:0] raw,
  input logic [DATA_W-1:0] mask,
  input logic              rx_en
);
  // R7
  tx_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_word == W_DOUT) |=> (tx_valid && tx_data == $past(wbyte)));
  // R7
  tx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_we && bus_word == W_DOUT) |=> !tx_valid);
  // R12
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |=> bus_rvalid);
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> (level < LW'(DEPTH)));
  // R5
  ready_en_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> rx_en);
  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(raw & mask))));
  // R6
  live_bit_chk: assert property (@(posedge clk) disable iff (rst)
    raw[RX_IRQ_BIT] == (level != '0));
  // R3
  pop_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && bus_word == W_STAT_POP && level != '0 && !(rx_valid && rx_ready))
      |=> (level == $past(level) - 1'b1));
endmodule

bind uart_reg_front uart_reg_front_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word),
  .wbyte(bus_wdata[7:0]), .bus_rvalid(bus_rvalid), .tx_valid(tx_valid),
  .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq),
  .level(fifo_level), .raw(irq_raw), .mask(mask_word), .rx_en(rx_en)
);

// File: tb/test_uart_reg_front.sv
module test_uart_reg_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_data;
  int n_chk = 0, n_fail = 0;

  localparam logic [3:0] I_TXCTL = 4'd0, I_DMA = 4'd1, I_RXCTL = 4'd2, I_SCR = 4'd3,
    I_SCR2 = 4'd10, I_DOUT = 4'd7, I_POP = 4'd8, I_PEEK = 4'd9, I_MASK = 4'd11,
    I_ACK = 4'd12, I_RAW = 4'd13, I_MSKD = 4'd14, I_OUT = 4'd15;
  localparam logic [31:0] ST_FIXED = 32'h0140_0000;
  localparam logic [31:0] ST_AVAIL = 32'h0001_0000;

  always #4 clk = ~clk;

  uart_reg_front i_uart_reg_front (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] w, input logic [31:0] d);
    @(negedge clk); bus_req = 1'b1; bus_we = 1'b1; bus_word = w; bus_wdata = d;
    @(negedge clk); bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] w, output logic [31:0] d);
    @(negedge clk); bus_req = 1'b1; bus_we = 1'b0; bus_word = w;
    @(negedge clk); bus_req = 1'b0; d = bus_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 0);
    rd(I_RXCTL, d); chk("R1 rx ctrl", d, 32'h0001_0000);
    rd(I_MASK, d);  chk("R1 mask", d, 0);
    rd(I_RAW, d);   chk("R1 raw", d, 0);
    rd(I_PEEK, d);  chk("R1 empty status", d & 32'hFFFF_FF00, ST_FIXED);
    push(8'h55);
    rd(I_PEEK, d);  chk("R5 disabled drop", d & 32'hFFFF_FF00, ST_FIXED);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    @(negedge clk); bus_req = 1'b1; bus_we = 1'b0; bus_word = I_RXCTL;
    @(negedge clk); bus_req = 1'b0;
    chk("R12 rvalid", {31'b0, bus_rvalid}, 1);
    @(negedge clk);
    chk("R12 rvalid drop", {31'b0, bus_rvalid}, 0);
    wr(I_TXCTL, 32'hDEAD_BEEF); wr(I_DMA, 32'h0000_0001);
    wr(I_SCR, 32'h1234_5678);   wr(I_SCR2, 32'hA5A5_0F0F);
    rd(I_TXCTL, d); chk("R10 tx ctrl", d, 32'hDEAD_BEEF);
    rd(I_DMA, d);   chk("R10 dma", d, 32'h0000_0001);
    rd(I_SCR, d);   chk("R10 spare 3", d, 32'h1234_5678);
    rd(I_SCR2, d);  chk("R10 spare 10", d, 32'hA5A5_0F0F);
    wr(I_RAW, 32'hFFFF_FFFF); wr(I_MSKD, 32'hFFFF_FFFF); wr(I_PEEK, 32'hFFFF_FFFF);
    rd(I_RAW, d);   chk("R10 raw write ignored", d, 0);
    rd(I_MSKD, d);  chk("R10 masked write ignored", d, 0);
    rd(I_PEEK, d);  chk("R10 status write ignored", d & 32'hFFFF_FF00, ST_FIXED);
    wr(I_OUT, 32'h7777_7777);
    rd(I_OUT, d);   chk("R12 out of window", d, 0);
  endtask

  task automatic t_fifo;
    logic [31:0] d;
    wr(I_RXCTL, 32'h0001_0008);
    chk("R5 ready enabled", {31'b0, rx_ready}, 1);
    push(8'h3C);
    rd(I_PEEK, d); chk("R2 peek byte", d, ST_FIXED | ST_AVAIL | 32'h3C);
    rd(I_PEEK, d); chk("R2 peek again", d, ST_FIXED | ST_AVAIL | 32'h3C);
    rd(I_RAW, d);  chk("R6 live bit set", d, 32'h8);
    rd(I_POP, d);  chk("R3 pop byte", d, ST_FIXED | ST_AVAIL | 32'h3C);
    rd(I_POP, d);  chk("R3 pop empty", d & 32'hFFFF_FF00, ST_FIXED);
    rd(I_RAW, d);  chk("R6 live bit clear", d, 0);
    for (int i = 0; i < 16; i++) push(8'hA0 + 8'(i));
    chk("R4 full ready low", {31'b0, rx_ready}, 0);
    push(8'hEE);
    for (int i = 0; i < 16; i++) begin
      rd(I_POP, d); chk("R4 order", d, ST_FIXED | ST_AVAIL | (32'hA0 + 32'(i)));
    end
    rd(I_PEEK, d); chk("R4 drop left empty", d & 32'hFFFF_FF00, ST_FIXED);
    wr(I_RXCTL, 32'h0001_0000);
    chk("R5 ready disabled", {31'b0, rx_ready}, 0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    wr(I_RXCTL, 32'h0000_0008);
    push(8'h11);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h22;
    bus_req = 1'b1; bus_we = 1'b0; bus_word = I_POP;
    @(negedge clk);
    rx_valid = 1'b0; bus_req = 1'b0; d = bus_rdata;
    chk("R11 pop gets older", d, ST_FIXED | ST_AVAIL | 32'h11);
    rd(I_PEEK, d); chk("R11 newer kept", d, ST_FIXED | ST_AVAIL | 32'h22);
    rd(I_POP, d);  chk("R11 pop newer", d, ST_FIXED | ST_AVAIL | 32'h22);
    rd(I_PEEK, d); chk("R11 then empty", d & 32'hFFFF_FF00, ST_FIXED);
  endtask

  task automatic t_tx_ack;
    logic [31:0] d;
    wr(I_DOUT, 32'h1234_56C3);
    chk("R7 tx strobe", {31'b0, tx_valid}, 1);
    chk("R7 tx byte", {24'b0, tx_data}, 32'hC3);
    @(negedge clk);
    chk("R7 one cycle", {31'b0, tx_valid}, 0);
    rd(I_RAW, d);  chk("R7 raw bits", d, 32'h3);
    rd(I_DOUT, d); chk("R10 dout readback", d, 32'h1234_56C3);
    wr(I_ACK, 32'h3);
    rd(I_RAW, d);  chk("R8 first ack spares bit0", d, 32'h1);
    rd(I_ACK, d);  chk("R8 ack readback", d, 32'h2);
    wr(I_ACK, 32'h1);
    rd(I_RAW, d);  chk("R8 second ack clears", d, 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(I_MASK, 32'h8);
    push(8'h99);
    @(negedge clk); @(negedge clk);
    chk("R9 irq on rx", {31'b0, irq}, 1);
    rd(I_MSKD, d); chk("R9 masked", d, 32'h8);
    wr(I_ACK, 32'h8);
    rd(I_RAW, d);  chk("R6 ack no effect", d, 32'h8);
    rd(I_POP, d);
    @(negedge clk); @(negedge clk);
    chk("R9 irq off", {31'b0, irq}, 0);
    wr(I_MASK, 32'h2);
    wr(I_DOUT, 32'h41);
    rd(I_MSKD, d); chk("R9 masked tx", d, 32'h2);
    chk("R9 irq tx", {31'b0, irq}, 1);
    wr(I_ACK, 32'h2);
    @(negedge clk); @(negedge clk);
    chk("R9 irq acked", {31'b0, irq}, 0);
    rd(I_MSKD, d); chk("R9 masked hides bit0", d, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_fifo();
    t_same_cycle();
    t_tx_ack();
    t_irq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule